// File: doc/BRIEF.md
# Aggregate Event Counter Pair

This block holds two free-running event counters for a wide superscalar core. Each counter takes its event source from a small select field. The first counter counts either retired instructions or clock cycles. The second counter counts cycles, cache misses and long-latency probes, or memory-unit replay traps. It can also be parked in an undefined mode, where it holds its value.

Up to eleven instructions may retire in one cycle, but the first counter can add at most eight per cycle. The surplus is kept in a small deficit register and paid back in later cycles, so the long-run total stays exact. Cache-miss events are taken three cycles ahead of a measurement window. Each counter has a sticky overflow interrupt request, gated by its own enable bit and cleared by a write-one-to-clear input.

Top module: `agg_perf_counters`

## Requirements
- R1: The retire count for a cycle is the number of lanes i (0 to 10) with retireValid[i]=1 and retireSquash[i]=0; squashed lanes never count.
- R2: In retire mode counter 0 adds min(8, retires + deficit) in each enabled cycle, and keeps the remainder as the new deficit, so the total stays exact when retirement is not sustained above 8.
- R3: The deficit is 3 bits wide; a remainder above 7 is stored as 7.
- R4: Counter 0 advances only when ctr0En=1 and at least one of sysEn or procEn is 1.
- R5: Select codes {sel0,sel1}: 000 means counter 0 counts retires and counter 1 counts cycles; 001 means cycles and hold; 010 means retires and misses; 011 means cycles and replay traps. With sel0=1 both counters hold.
- R6: In cycle mode a counter adds exactly 1 per enabled cycle.
- R7: A missEvent at clock edge e is counted by counter 1 in miss mode if and only if measWindow is 1 at edge e+3 and counter 1 is enabled at that edge.
- R8: Counter 1 advances only when ctr1En=1 and at least one of sysEn or procEn is 1. In code 001 it holds its value.
- R9: clrCtr[0] zeroes counter 0 and its deficit, and clrCtr[1] zeroes counter 1. A clear takes priority over counting. Neither counter is ever zeroed by any other means.
- R10: Counters are CNT_W bits wide and wrap to 0. On a wrap, irq[k] is set if irqEn[k]=1. irq[k] stays set until irqAck[k]=1. If a set and an acknowledge occur in the same cycle, the set wins.
- R11: While counter 0 is disabled its deficit is kept. Any change of {sel0,sel1} from the previous cycle discards the deficit before that cycle's count.
- R12: After reset both counters, the deficit, the miss pipeline and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 11 | Per-lane retire strobes |
| retireSquash | input | 11 | Per-lane squash marks |
| missEvent | input | 1 | Cache miss or long-latency probe strobe |
| replayEvent | input | 1 | Memory-unit replay trap strobe |
| measWindow | input | 1 | Measurement window open |
| ctr0En | input | 1 | Counter 0 enable |
| ctr1En | input | 1 | Counter 1 enable |
| sysEn | input | 1 | System-level count enable |
| procEn | input | 1 | Per-process count enable |
| sel0 | input | 1 | Counter 0 select bit |
| sel1 | input | 2 | Counter 1 select field |
| clrCtr | input | 2 | Software clear, bit k for counter k |
| irqEn | input | 2 | Interrupt enable per counter |
| irqAck | input | 2 | Write-one-to-clear of irq |
| ctr0Val | output | CNT_W | Counter 0 value |
| ctr1Val | output | CNT_W | Counter 1 value |
| irq | output | 2 | Sticky overflow interrupt requests |

## Verification
The retire path is swept over every one of the 2048 valid masks, each paired with a rotating squash mask. A wrong lane mask or miscount shows up as a per-cycle error. Bursts of 9 to 11 retires separated by quiet cycles test deficit repayment, and unbroken runs of 11 test the saturation at 7. These are interleaved with disable windows and select changes, which separate holding the deficit from dropping it. Single miss pulses placed at known offsets from the window edges show whether the three-cycle lead is exact. A narrow counter width is used so that wrap, the interrupt gating and the acknowledge race are reached within a few hundred cycles.

// File: rtl/agg_perf_pkg.sv
package agg_perf_pkg;

  typedef enum logic [1:0] {
    C1_CYCLES = 2'b00,
    C1_HOLD   = 2'b01,
    C1_MISS   = 2'b10,
    C1_REPLAY = 2'b11
  } ctr1Mode_t;

  typedef struct packed {
    logic countRetire;
    logic countCycle0;
    logic bump1;
    logic clear0;
    logic clear1;
    logic dropDebt;
  } ctlStrobe_t;

endpackage

// File: rtl/agg_perf_irq.sv
module agg_perf_irq (
  input  logic clk,
  input  logic rstN,
  input  logic setReq,
  input  logic enable,
  input  logic ack,
  output logic flag
);
  logic flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= (flagQ & ~ack) | (setReq & enable);
  end

  assign flag = flagQ;
endmodule

// File: rtl/agg_perf_ctrl.sv
module agg_perf_ctrl
  import agg_perf_pkg::*;
#(
  parameter int MISS_LEAD = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       missEvent,
  input  logic       replayEvent,
  input  logic       measWindow,
  input  logic       ctr0En,
  input  logic       ctr1En,
  input  logic       sysEn,
  input  logic       procEn,
  input  logic       sel0,
  input  logic [1:0] sel1,
  input  logic [1:0] clrCtr,
  output ctlStrobe_t strobe
);
  localparam int SEL_W = 3;

  logic [SEL_W-1:0] selNow;
  logic [SEL_W-1:0] selPrevQ;
  logic             anyEn;
  logic             go0;
  logic             go1;
  logic             missLate;
  ctr1Mode_t        mode1;

  assign selNow = {sel0, sel1};
  assign anyEn  = sysEn | procEn;
  assign mode1  = ctr1Mode_t'(sel1);

  always_ff @(posedge clk) begin
    if (!rstN) selPrevQ <= '0;
    else       selPrevQ <= selNow;
  end

  generate
    if (MISS_LEAD <= 1) begin : gLeadOne
      logic missQ;
      always_ff @(posedge clk) begin
        if (!rstN) missQ <= 1'b0;
        else       missQ <= missEvent;
      end
      assign missLate = missQ;
    end else begin : gLeadMany
      logic [MISS_LEAD-1:0] missPipeQ;
      always_ff @(posedge clk) begin
        if (!rstN) missPipeQ <= '0;
        else       missPipeQ <= {missPipeQ[MISS_LEAD-2:0], missEvent};
      end
      assign missLate = missPipeQ[MISS_LEAD-1];
    end
  endgenerate

  assign go0 = !sel0 && ctr0En && anyEn && !clrCtr[0];
  assign go1 = !sel0 && ctr1En && anyEn && !clrCtr[1];

  always_comb begin
    strobe             = '0;
    strobe.clear0      = clrCtr[0];
    strobe.clear1      = clrCtr[1];
    strobe.dropDebt    = (selNow != selPrevQ);
    strobe.countRetire = go0 && !sel1[0];
    strobe.countCycle0 = go0 &&  sel1[0];
    unique case (mode1)
      C1_CYCLES: strobe.bump1 = go1;
      C1_HOLD:   strobe.bump1 = 1'b0;
      C1_MISS:   strobe.bump1 = go1 && missLate && measWindow;
      C1_REPLAY: strobe.bump1 = go1 && replayEvent;
      default:   strobe.bump1 = 1'b0;
    endcase
  end
endmodule

// File: rtl/agg_perf_dp.sv
module agg_perf_dp
  import agg_perf_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int LANES   = 11,
  parameter int MAX_ADD = 8,
  parameter int DEBT_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] retireValid,
  input  logic [LANES-1:0] retireSquash,
  input  ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] ctr0Val,
  output logic [CNT_W-1:0] ctr1Val,
  output logic [1:0]       wrapPulse
);
  localparam int POP_W    = $clog2(LANES + 1);
  localparam int DEBT_MAX = (1 << DEBT_W) - 1;
  localparam int SUM_W    = $clog2(LANES + DEBT_MAX + 1);

  logic [CNT_W-1:0]  ctr0Q, ctr1Q;
  logic [DEBT_W-1:0] debtQ, debtIn, debtNext;
  logic [POP_W-1:0]  liveCnt;
  logic [SUM_W-1:0]  sumAll, addRet, leftover, inc0Amt;
  logic [CNT_W:0]    next0, next1;

  function automatic logic [POP_W-1:0] countLive(input logic [LANES-1:0] v);
    logic [POP_W-1:0] c;
    c = '0;
    for (int i = 0; i < LANES; i++) c = c + POP_W'(v[i]);
    return c;
  endfunction

  assign liveCnt  = countLive(retireValid & ~retireSquash);
  assign debtIn   = strobe.dropDebt ? '0 : debtQ;
  assign sumAll   = SUM_W'(liveCnt) + SUM_W'(debtIn);
  assign addRet   = (sumAll > SUM_W'(MAX_ADD)) ? SUM_W'(MAX_ADD) : sumAll;
  assign leftover = sumAll - addRet;
  assign debtNext = (leftover > SUM_W'(DEBT_MAX)) ? DEBT_W'(DEBT_MAX)
                                                  : leftover[DEBT_W-1:0];

  always_comb begin
    if (strobe.countRetire)      inc0Amt = addRet;
    else if (strobe.countCycle0) inc0Amt = SUM_W'(1);
    else                         inc0Amt = '0;
  end

  assign next0 = {1'b0, ctr0Q} + (CNT_W+1)'(inc0Amt);
  assign next1 = {1'b0, ctr1Q} + (CNT_W+1)'(strobe.bump1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctr0Q <= '0;
      debtQ <= '0;
    end else if (strobe.clear0) begin
      ctr0Q <= '0;
      debtQ <= '0;
    end else begin
      ctr0Q <= next0[CNT_W-1:0];
      debtQ <= strobe.countRetire ? debtNext : debtIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              ctr1Q <= '0;
    else if (strobe.clear1) ctr1Q <= '0;
    else                    ctr1Q <= next1[CNT_W-1:0];
  end

  assign wrapPulse[0] = !strobe.clear0 && next0[CNT_W];
  assign wrapPulse[1] = !strobe.clear1 && next1[CNT_W];
  assign ctr0Val      = ctr0Q;
  assign ctr1Val      = ctr1Q;
endmodule

// File: rtl/agg_perf_counters.sv
module agg_perf_counters
  import agg_perf_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int LANES     = 11,
  parameter int MAX_ADD   = 8,
  parameter int DEBT_W    = 3,
  parameter int MISS_LEAD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] retireValid,
  input  logic [LANES-1:0] retireSquash,
  input  logic             missEvent,
  input  logic             replayEvent,
  input  logic             measWindow,
  input  logic             ctr0En,
  input  logic             ctr1En,
  input  logic             sysEn,
  input  logic             procEn,
  input  logic             sel0,
  input  logic [1:0]       sel1,
  input  logic [1:0]       clrCtr,
  input  logic [1:0]       irqEn,
  input  logic [1:0]       irqAck,
  output logic [CNT_W-1:0] ctr0Val,
  output logic [CNT_W-1:0] ctr1Val,
  output logic [1:0]       irq
);
  ctlStrobe_t strobe;
  logic [1:0] wrapPulse;

  agg_perf_ctrl #(.MISS_LEAD(MISS_LEAD)) uCtrl (
    .clk, .rstN, .missEvent, .replayEvent, .measWindow,
    .ctr0En, .ctr1En, .sysEn, .procEn, .sel0, .sel1, .clrCtr,
    .strobe(strobe)
  );

  agg_perf_dp #(.CNT_W(CNT_W), .LANES(LANES), .MAX_ADD(MAX_ADD), .DEBT_W(DEBT_W)) uDp (
    .clk, .rstN, .retireValid, .retireSquash, .strobe(strobe),
    .ctr0Val, .ctr1Val, .wrapPulse(wrapPulse)
  );

  for (genvar k = 0; k < 2; k++) begin : gIrq
    agg_perf_irq uIrq (
      .clk, .rstN, .setReq(wrapPulse[k]), .enable(irqEn[k]),
      .ack(irqAck[k]), .flag(irq[k])
    );
  end
endmodule

// File: rtl/agg_perf_chk.sv
module agg_perf_chk #(
  parameter int CNT_W   = 20,
  parameter int MAX_ADD = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctr0En,
  input logic             ctr1En,
  input logic             sysEn,
  input logic             procEn,
  input logic             sel0,
  input logic [1:0]       sel1,
  input logic [1:0]       clrCtr,
  input logic [1:0]       irqEn,
  input logic [1:0]       irqAck,
  input logic [CNT_W-1:0] ctr0Val,
  input logic [CNT_W-1:0] ctr1Val,
  input logic [1:0]       irq
);
  // R2: per-cycle growth of counter 0 bounded by MAX_ADD
  a_r2_max_step: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrCtr[0]) |-> (CNT_W'(ctr0Val - $past(ctr0Val)) <= CNT_W'(MAX_ADD)));

  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!(ctr0En && (sysEn || procEn)) && !clrCtr[0]) |=> $stable(ctr0Val));

  a_r8_hold_mode: assert property (@(posedge clk) disable iff (!rstN)
    ({sel0, sel1} == 3'b001 && !clrCtr[1]) |=> $stable(ctr1Val));

  a_r9_clear1: assert property (@(posedge clk) disable iff (!rstN)
    clrCtr[1] |=> (ctr1Val == '0));

  a_r10_gated_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq[0]) |-> $past(irqEn[0]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq[1] && !irqAck[1]) |=> irq[1]);

  a_r10_gated_irq1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq[1]) |-> $past(irqEn[1]));
endmodule

bind agg_perf_counters agg_perf_chk #(.CNT_W(CNT_W), .MAX_ADD(MAX_ADD)) uChk (.*);

// File: tb/tb_agg_perf_counters.sv
module tb_agg_perf_counters;
  localparam int CW  = 8;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] valid = '0, squash = '0;
  logic miss = 0, replay = 0, win = 0, en0 = 0, en1 = 0, sys = 0, procEn = 0, s0 = 0;
  logic [1:0] s1 = '0, clr = '0, ie = '0, ack = '0;
  logic [CW-1:0] c0, c1;
  logic [1:0] irq;

  int vecs = 0, bad = 0;
  int m0 = 0, m1 = 0, mDebt = 0;
  bit [1:0] mIrq = '0;
  bit [2:0] mPipe = '0, mPrev = '0;
  bit done = 0;

  always #5 clk = ~clk;

  agg_perf_counters #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .retireValid(valid), .retireSquash(squash),
    .missEvent(miss), .replayEvent(replay), .measWindow(win),
    .ctr0En(en0), .ctr1En(en1), .sysEn(sys), .procEn(procEn),
    .sel0(s0), .sel1(s1), .clrCtr(clr), .irqEn(ie), .irqAck(ack),
    .ctr0Val(c0), .ctr1Val(c1), .irq(irq)
  );

  task automatic compare(input string tag);
    vecs++;
    if (c0 !== CW'(m0) || c1 !== CW'(m1) || irq !== mIrq) begin
      bad++;
      $display("FAIL %s: ctr0=%0d ctr1=%0d irq=%b expected ctr0=%0d ctr1=%0d irq=%b",
               tag, c0, c1, irq, m0, m1, mIrq);
    end
  endtask

  task automatic tick(input string tag);
    int pop, eff, sum, add, n0, n1;
    bit ov0, ov1, act, bump;
    bit [2:0] code;
    @(posedge clk);
    pop  = $countones(valid & ~squash);
    code = {s0, s1};
    eff  = (code != mPrev) ? 0 : mDebt;
    act  = sys | procEn;
    ov0 = 0; ov1 = 0;
    if (clr[0]) begin m0 = 0; mDebt = 0; end
    else if (!s0 && en0 && act) begin
      if (!s1[0]) begin
        sum = pop + eff; add = (sum > 8) ? 8 : sum;
        mDebt = (sum - add > 7) ? 7 : sum - add;
        n0 = m0 + add;
      end else begin
        n0 = m0 + 1; mDebt = eff;
      end
      if (n0 >= MOD) begin n0 -= MOD; ov0 = 1; end
      m0 = n0;
    end else mDebt = eff;
    if (clr[1]) m1 = 0;
    else if (!s0 && en1 && act) begin
      case (s1)
        2'b00:   bump = 1;
        2'b10:   bump = mPipe[2] && win;
        2'b11:   bump = replay;
        default: bump = 0;
      endcase
      n1 = m1 + int'(bump);
      if (n1 >= MOD) begin n1 -= MOD; ov1 = 1; end
      m1 = n1;
    end
    mIrq  = (mIrq & ~ack) | ({ov1, ov0} & ie);
    mPipe = {mPipe[1:0], miss};
    mPrev = code;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    valid = '0; miss = 0; replay = 0; clr = '0; ack = '0;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic setMode(input bit a, input bit [1:0] b);
    s0 = a; s1 = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R12 during reset");
    rstN = 1;
    tick("R12 after reset");

    // R1 / R2: every valid mask with rotating squash masks
    en0 = 1; sys = 1; setMode(0, 2'b00);
    for (int v = 0; v < 2048; v++) begin
      valid = 11'(v); squash = 11'((v * 37) ^ (v >> 3));
      tick("R1 lane sweep");
    end
    idle(3, "R2 drain");

    // R2: bursts of 9..11 then quiet cycles
    for (int b = 9; b <= 11; b++) begin
      squash = '0; valid = 11'((1 << b) - 1);
      tick("R2 burst");
      idle(2, "R2 repay");
    end

    // R3: sustained 11 saturates deficit at 7
    valid = '1; squash = '0;
    for (int i = 0; i < 6; i++) tick("R3 sustained");
    idle(3, "R3 drain");

    // R4: enable combinations
    for (int e = 0; e < 8; e++) begin
      en0 = e[0]; sys = e[1]; procEn = e[2]; valid = 11'h0FF;
      tick("R4 enable combo"); tick("R4 enable combo");
    end
    en0 = 1; sys = 1; procEn = 0;

    // R5 / R6 / R8: every select code with counter 1 enabled
    en1 = 1;
    for (int c = 0; c < 8; c++) begin
      setMode(c[2], 2'(c));
      for (int i = 0; i < 6; i++) begin
        valid = 11'(i * 181); replay = i[0]; miss = i[1]; win = 1;
        tick(c[0] ? "R6 cycle mode" : "R5 select");
      end
    end
    for (int e = 0; e < 8; e++) begin
      setMode(0, 2'b00); en1 = e[0]; sys = e[1]; procEn = e[2];
      tick("R8 enable combo");
    end
    en1 = 1; sys = 1; procEn = 0;

    // R7: single miss pulses at known offsets from window edges
    setMode(0, 2'b10);
    for (int off = 0; off < 6; off++) begin
      idle(4, "R7 settle");
      miss = 1; win = 0; tick("R7 pulse");
      miss = 0;
      for (int j = 1; j <= 6; j++) begin win = (j == off); tick("R7 window"); end
    end
    for (int i = 0; i < 400; i++) begin
      miss = $urandom_range(1, 0); win = $urandom_range(3, 0) != 0;
      tick("R7 random window");
    end

    // R9: clears and priority over counting
    setMode(0, 2'b00); valid = '1;
    tick("R9 prep"); clr = 2'b01; tick("R9 clear0"); clr = 2'b10; tick("R9 clear1");
    clr = 2'b11; tick("R9 clear both"); clr = 2'b00; idle(5, "R9 no auto clear");

    // R10: wrap, gating and acknowledge race
    setMode(0, 2'b01); ie = 2'b01;
    for (int i = 0; i < 300; i++) tick("R10 wrap ctr0");
    ack = 2'b01; tick("R10 ack"); ack = 0;
    setMode(0, 2'b00); ie = 2'b10;
    for (int i = 0; i < 300; i++) begin
      ack = (i % 7 == 0) ? 2'b11 : 2'b00; tick("R10 wrap ctr1 race");
    end
    ie = 2'b00; for (int i = 0; i < 260; i++) tick("R10 gated off");

    // R11: deficit kept while disabled, dropped on select change
    setMode(0, 2'b00); ack = 0;
    valid = '1; tick("R11 build"); valid = 0; en0 = 0;
    idle(3, "R11 disabled"); en0 = 1; idle(2, "R11 repay held");
    valid = '1; tick("R11 build"); valid = 0; setMode(0, 2'b10);
    idle(3, "R11 dropped");

    // mixed random
    for (int i = 0; i < 3000; i++) begin
      valid = 11'($urandom); squash = 11'($urandom);
      miss = $urandom_range(1, 0); replay = $urandom_range(1, 0);
      win = $urandom_range(1, 0); en0 = $urandom_range(7, 0) != 0;
      en1 = $urandom_range(7, 0) != 0; sys = $urandom_range(1, 0);
      procEn = $urandom_range(1, 0);
      if ($urandom_range(15, 0) == 0) setMode($urandom_range(5, 0) == 0, 2'($urandom));
      clr = ($urandom_range(31, 0) == 0) ? 2'($urandom) : 2'b00;
      ie = 2'($urandom); ack = ($urandom_range(3, 0) == 0) ? 2'($urandom) : 2'b00;
      tick("R2 R5 R10 random mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule